// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block takes one reference clock and derives two slower event streams from it. The first stream comes from a 13-bit programmable counter. It emits a one-cycle high pulse for each completed divide period, and this pulse serves as the comparison reference of a phase detector. The second stream comes from a small power-of-two prescaler that drives the reference output. That output is active only in the output-capable operating modes.

A 3-bit mode code is captured together with the divide value on a load strobe. The mode code decides three things:

- whether the oscillator enable is raised;
- whether the counter may run;
- which ratio, if any, the reference output uses.

A standby input freezes the programmable counter in place. It leaves the oscillator enable and the reference output untouched. Divide values below the legal floor are forced up to it, except the value one, which selects a pass-through where every enabled input cycle yields a pulse.

Top module: `refdiv_top`

## Requirements
- R1: After reset, ref_pulse and ref_out are low and osc_en is high. The divide value is 10 and the mode is 110, so the reference output ratio is 8.
- R2: When load is high at a rising edge, div_in and mode_in are captured at that edge and both internal counts restart from zero. With a divide value N, the first pulse appears N enabled edges after the load edge.
- R3: For a divide value N from 10 to 8191, ref_pulse is high for exactly one cycle once every N enabled cycles and is otherwise low.
- R4: A divide value of 1 makes ref_pulse high in every enabled cycle.
- R5: Divide values 0 and 2 through 9 are clamped to 10.
- R6: osc_en is low exactly when the captured mode is 000, whatever the state of standby.
- R7: While standby is high, the programmable counter holds its count and ref_pulse is low. When standby drops, counting resumes from the held count.
- R8: In mode 000 the counter is halted, and ref_pulse and ref_out are low.
- R9: In modes 001 and 010 the counter runs and ref_out is held low.
- R10: Modes 011, 100, 101, 110 and 111 make ref_out pulse high for one cycle once per 1, 2, 4, 8 and 16 input cycles respectively. Standby does not affect this.
- R11: While load is high, both counts stay at zero and ref_pulse and ref_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Holds the programmable counter while high |
| div_in | input | 13 | Divide value to capture on load |
| mode_in | input | 3 | Mode code to capture on load |
| load | input | 1 | Capture strobe for div_in and mode_in |
| ref_pulse | output | 1 | One-cycle pulse per divide period |
| ref_out | output | 1 | Prescaled reference output pulse stream |
| osc_en | output | 1 | Oscillator enable, low only in mode 000 |

## Verification
Two events can fall on the same edge: a load strobe and the programmable counter's terminal count. A standby change can also coincide with a prescaler tick. The bench issues loads and standby toggles at phases that are not aligned to either count period. A behavioural model then decides, edge by edge, what each output must be:

- a load always wins and clears both streams;
- standby suppresses only ref_pulse, while ref_out keeps ticking on its own schedule.

Every output is compared against this model on every cycle.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    typedef enum logic [2:0] {
        MD_SHUT  = 3'b000,
        MD_XTAL  = 3'b001,
        MD_NOOUT = 3'b010,
        MD_DIV1  = 3'b011,
        MD_DIV2  = 3'b100,
        MD_DIV4  = 3'b101,
        MD_DIV8  = 3'b110,
        MD_DIV16 = 3'b111
    } mode_e;

    localparam mode_e MODE_RESET = MD_DIV8;

    // Output modes start at code 011; their ratio is 2**(code-3).
    function automatic logic out_active(mode_e m);
        return m >= MD_DIV1;
    endfunction

    function automatic logic [2:0] out_shift(mode_e m);
        return 3'(m) - 3'd3;
    endfunction

endpackage

// File: rtl/refdiv_cfg.sv
module refdiv_cfg
    import refdiv_pkg::*;
#(
    parameter int CNT_W   = 13,
    parameter int MIN_DIV = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] div_in,
    input  logic [2:0]       mode_in,
    output logic [CNT_W-1:0] div_q,
    output mode_e            mode_q
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_DIV);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] div;
        mode_e            mode;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [CNT_W-1:0] div_fixed;

    always_comb begin
        if (div_in == ONE) begin
            div_fixed = ONE;
        end else if (div_in < FLOOR) begin
            div_fixed = FLOOR;
        end else begin
            div_fixed = div_in;
        end

        st_d = st_q;
        if (load) begin
            st_d.div  = div_fixed;
            st_d.mode = mode_e'(mode_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div  <= FLOOR;
            st_q.mode <= MODE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_q  = st_q.div;
    assign mode_q = st_q.mode;

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] div,
    output logic             pulse
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = div - CNT_W'(1);
        st_d = st_q;

        if (load) begin
            st_d.cnt   = '0;
            st_d.pulse = 1'b0;
        end else if (run) begin
            if (st_q.cnt >= last) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt   = st_q.cnt + CNT_W'(1);
                st_d.pulse = 1'b0;
            end
        end else begin
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

endmodule

// File: rtl/refdiv_prescale.sv
module refdiv_prescale
    import refdiv_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  mode_e mode,
    output logic  tick
);

    localparam int RATIO_W = PRE_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic             tick;
    } pre_t;

    pre_t st_d, st_q;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] last;

    always_comb begin
        ratio = RATIO_W'(1) << out_shift(mode);
        last  = ratio - RATIO_W'(1);
        st_d  = st_q;

        if (load || !out_active(mode)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else if ({1'b0, st_q.cnt} >= last) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + PRE_W'(1);
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
#(
    parameter int CNT_W   = 13,
    parameter int MIN_DIV = 10,
    parameter int PRE_W   = 4
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic [CNT_W-1:0] div_in,
    input  logic [2:0]       mode_in,
    input  logic             load,
    output logic             ref_pulse,
    output logic             ref_out,
    output logic             osc_en
);

    logic [CNT_W-1:0] cfg_div;
    mode_e            cfg_mode;
    logic             run;

    refdiv_cfg #(
        .CNT_W  (CNT_W),
        .MIN_DIV(MIN_DIV)
    ) u_cfg (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .load   (load),
        .div_in (div_in),
        .mode_in(mode_in),
        .div_q  (cfg_div),
        .mode_q (cfg_mode)
    );

    assign osc_en = (cfg_mode != MD_SHUT);
    assign run    = osc_en && !standby;

    refdiv_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .load (load),
        .run  (run),
        .div  (cfg_div),
        .pulse(ref_pulse)
    );

    refdiv_prescale #(
        .PRE_W(PRE_W)
    ) u_pre (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .load (load),
        .mode (cfg_mode),
        .tick (ref_out)
    );

endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker #(
    parameter int CNT_W   = 13,
    parameter int MIN_DIV = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             standby,
    input logic [2:0]       mode_in,
    input logic [CNT_W-1:0] cfg_div,
    input logic             ref_pulse,
    input logic             ref_out,
    input logic             osc_en
);

    // R3: with a divide value above one, a pulse never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pulse && cfg_div > CNT_W'(1)) |=> !ref_pulse);

    // R5: the captured divide value is either the bypass value or at least the floor
    a_r5_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div == CNT_W'(1)) || (cfg_div >= CNT_W'(MIN_DIV)));

    // R6: loading mode 000 drops the oscillator enable
    a_r6_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode_in == 3'b000) |=> !osc_en);

    // R7: a standby cycle yields no pulse
    a_r7_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !ref_pulse);

    // R8: with the oscillator off both outputs are quiet
    a_r8_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!ref_pulse && !ref_out));

    // R11: a load edge clears both outputs
    a_r11_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!ref_pulse && !ref_out));

endmodule

bind refdiv_top refdiv_checker #(
    .CNT_W  (CNT_W),
    .MIN_DIV(MIN_DIV)
) u_chk (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .load     (load),
    .standby  (standby),
    .mode_in  (mode_in),
    .cfg_div  (cfg_div),
    .ref_pulse(ref_pulse),
    .ref_out  (ref_out),
    .osc_en   (osc_en)
);

// File: tb/refdiv_top_test.sv
module refdiv_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        standby;
    logic        load;
    logic [12:0] div_in;
    logic [2:0]  mode_in;
    logic        ref_pulse;
    logic        ref_out;
    logic        osc_en;

    always #4 clk = ~clk;

    refdiv_top uut (
        .ref_clk  (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .div_in   (div_in),
        .mode_in  (mode_in),
        .load     (load),
        .ref_pulse(ref_pulse),
        .ref_out  (ref_out),
        .osc_en   (osc_en)
    );

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;

    // behavioural reference model
    int m_div, m_mode, m_cnt, m_pre;
    bit m_pulse, m_out;

    function automatic int clampv(int v);
        if (v == 1) return 1;
        if (v < 10) return 10;
        return v;
    endfunction

    function automatic int ratio_of(int m);
        return 1 << (m - 3);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 10; m_mode = 6; m_cnt = 0; m_pre = 0;
            m_pulse = 0; m_out = 0;
        end else if (load) begin
            m_cnt = 0; m_pre = 0; m_pulse = 0; m_out = 0;
            m_div = clampv(int'(div_in));
            m_mode = int'(mode_in);
        end else begin
            if (m_mode != 0 && !standby) begin
                if (m_cnt >= m_div - 1) begin m_cnt = 0; m_pulse = 1; end
                else begin m_cnt++; m_pulse = 0; end
            end else begin
                m_pulse = 0;
            end
            if (m_mode >= 3) begin
                if (m_pre >= ratio_of(m_mode) - 1) begin m_pre = 0; m_out = 1; end
                else begin m_pre++; m_out = 0; end
            end else begin
                m_pre = 0; m_out = 0;
            end
        end
    end

    task automatic check(input logic act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            check(ref_pulse, m_pulse, "R2/R3/R4/R5/R7/R8 ref_pulse");
            check(ref_out, m_out, "R8/R9/R10/R11 ref_out");
            check(osc_en, (m_mode != 0), "R6 osc_en");
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ld(input int d, input int m);
        @(negedge clk);
        load = 1'b1; div_in = 13'(d); mode_in = 3'(m);
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; standby = 1'b0; load = 1'b0; div_in = '0; mode_in = '0;
        idle(3);
        // R1: reset state
        check(ref_pulse, 1'b0, "R1 ref_pulse in reset");
        check(ref_out, 1'b0, "R1 ref_out in reset");
        check(osc_en, 1'b1, "R1 osc_en in reset");
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1/R3/R10: defaults of divide 10 and ratio 8
        idle(45);
        // R4/R10: bypass and ratio 1
        ld(1, 3); idle(12);
        // R5: clamped values, ratios 2 and 4
        ld(5, 4); idle(33);
        ld(0, 5); idle(27);
        // R2/R7/R10: standby toggled at odd phases, ratio 16
        ld(13, 7); idle(7);
        standby = 1'b1; idle(9);
        standby = 1'b0; idle(11);
        standby = 1'b1; idle(3);
        standby = 1'b0; idle(30);
        // R6/R8: shutdown with and without standby
        ld(20, 0); idle(25);
        standby = 1'b1; idle(5); standby = 1'b0; idle(5);
        // R9: counter runs with output held low
        ld(25, 1); idle(60);
        ld(12, 2); idle(40);
        // R11: load held for several cycles, then released mid-period
        @(negedge clk);
        load = 1'b1; div_in = 13'd11; mode_in = 3'd4;
        idle(5);
        load = 1'b0;
        idle(30);
        // R2: reload landing on a terminal count
        ld(10, 6); idle(9);
        ld(14, 6); idle(35);
        // R3: upper boundary 8191
        ld(8191, 6); idle(8200);
        cmp_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule